// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

The block owns a small word-addressed memory and executes one atomic read-modify-write request at a time. A request names an operation, a word address, a primary operand, a second operand that only compare-and-swap uses, a signedness bit for the max/min comparisons, and a bit that asks for the prior value of the word to be returned. The unit reads the word, computes the new value, writes it back and pulses a completion strobe. For returning requests the strobe carries the value the word held before the update.

Two saturating counters track compare-and-swap traffic. One counts every compare-and-swap. The other counts only those whose comparison failed. An opcode outside the eleven defined ones completes with an error pulse. It does not touch memory or the counters.

Top module: `amo_unit`

## Requirements
- R1: After reset `req_ready` is 1, `done_o`, `ret_valid_o` and `err_o` are 0, both counters are 0 and every memory word reads as 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge after acceptance until completion. `done_o` is high for exactly one cycle, starting at the second edge after the accepting edge, and `req_ready` is 1 again in that same cycle.
- R3: Opcode 0 stores old AND operand, opcode 1 stores old OR operand, and opcode 2 stores old XOR operand.
- R4: Opcode 5 adds the operand, opcode 6 subtracts it, opcode 7 adds exactly 1 and opcode 8 subtracts exactly 1. The increment and decrement take no operand. All four results are modulo 2^W.
- R5: Opcode 4 (exchange) stores the operand unconditionally.
- R6: Opcode 3 (compare-and-swap) stores the second operand only when the old word equals the primary operand. Otherwise the word is unchanged.
- R7: Every compare-and-swap raises `cas_attempts` by one, and a failed one also raises `cas_fails` by one. Both counters stop at 2^CW-1.
- R8: Opcode 9 (max) stores the operand only if it is greater than the old word, and opcode 10 (min) only if it is smaller. The comparison is two's-complement when `req_signed` is 1 and unsigned when it is 0.
- R9: When `req_ret` is 1, `ret_valid_o` pulses together with `done_o` and `rsp_data` holds the pre-update word. When `req_ret` is 0, `ret_valid_o` stays 0.
- R10: Opcodes 11 to 15 are illegal. They pulse `err_o` together with `done_o`, leave memory and both counters unchanged, and never raise `ret_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 4 | Operation code |
| req_addr | input | AW | Word address |
| req_opa | input | W | Primary operand (compare value for compare-and-swap) |
| req_opb | input | W | Swap value for compare-and-swap |
| req_ret | input | 1 | Return the old value |
| req_signed | input | 1 | Signed comparison for max/min |
| done_o | output | 1 | One-cycle completion pulse |
| ret_valid_o | output | 1 | Old value is valid on rsp_data |
| rsp_data | output | W | Pre-update word |
| err_o | output | 1 | Illegal opcode pulse |
| cas_attempts | output | CW | Saturating compare-and-swap count |
| cas_fails | output | CW | Saturating failed compare-and-swap count |

## Verification
A failing returning compare-and-swap delivers the old word on the response channel in the same cycle that both counters advance. The bench provokes this with a mismatching compare value and then checks the returned data, the unchanged word and both counters. Saturation is provoked by a long run of failing compare-and-swaps, after which each counter must sit exactly at its maximum while the last completions still carry correct results.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_CAS  = 4'd3,
        OP_EXCH = 4'd4,
        OP_ADD  = 4'd5,
        OP_SUB  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_MAX  = 4'd9,
        OP_MIN  = 4'd10
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } amo_state_e;

    function automatic logic op_is_legal(input logic [OP_W-1:0] code);
        return code <= 4'd10;
    endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    old_val,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic            sgn,
    output logic [W-1:0]    new_val,
    output logic            wr_en,
    output logic            cas_op,
    output logic            cas_miss,
    output logic            illegal
);
    logic opa_gt;
    logic opa_lt;

    always_comb begin
        if (sgn) begin
            opa_gt = $signed(opa) > $signed(old_val);
            opa_lt = $signed(opa) < $signed(old_val);
        end else begin
            opa_gt = opa > old_val;
            opa_lt = opa < old_val;
        end
    end

    always_comb begin
        new_val  = old_val;
        wr_en    = 1'b1;
        cas_op   = 1'b0;
        cas_miss = 1'b0;
        illegal  = !op_is_legal(op);
        case (op)
            OP_AND:  new_val = old_val & opa;
            OP_OR:   new_val = old_val | opa;
            OP_XOR:  new_val = old_val ^ opa;
            OP_CAS: begin
                cas_op = 1'b1;
                if (old_val == opa) new_val = opb;
                else begin
                    cas_miss = 1'b1;
                    wr_en    = 1'b0;
                end
            end
            OP_EXCH: new_val = opa;
            OP_ADD:  new_val = old_val + opa;
            OP_SUB:  new_val = old_val - opa;
            OP_INC:  new_val = old_val + {{(W-1){1'b0}}, 1'b1};
            OP_DEC:  new_val = old_val - {{(W-1){1'b0}}, 1'b1};
            OP_MAX: begin
                wr_en = opa_gt;
                if (opa_gt) new_val = opa;
            end
            OP_MIN: begin
                wr_en = opa_lt;
                if (opa_lt) new_val = opa;
            end
            default: wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);
    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
            rd_data <= '0;
        end else begin
            if (we) words[wr_addr] <= wr_data;
            rd_data <= words[rd_addr];
        end
    end
endmodule

// File: rtl/amo_cas_stats.sv
module amo_cas_stats #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bump,
    input  logic          miss,
    output logic [CW-1:0] attempts,
    output logic [CW-1:0] fails
);
    localparam int NCTR = 2;
    localparam logic [CW-1:0] CMAX = '1;

    logic [NCTR-1:0]   inc;
    logic [CW-1:0]     cnt [NCTR];

    assign inc = {bump & miss, bump};

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst) cnt[g] <= '0;
            else if (inc[g] && cnt[g] != CMAX) cnt[g] <= cnt[g] + 1'b1;
        end
    end

    assign attempts = cnt[0];
    assign fails    = cnt[1];
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int CW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [OP_W-1:0] req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [W-1:0]    req_opa,
    input  logic [W-1:0]    req_opb,
    input  logic            req_ret,
    input  logic            req_signed,
    output logic            done_o,
    output logic            ret_valid_o,
    output logic [W-1:0]    rsp_data,
    output logic            err_o,
    output logic [CW-1:0]   cas_attempts,
    output logic [CW-1:0]   cas_fails
);
    typedef struct packed {
        logic [OP_W-1:0] op;
        logic [AW-1:0]   addr;
        logic [W-1:0]    opa;
        logic [W-1:0]    opb;
        logic            ret;
        logic            sgn;
    } req_t;

    amo_state_e state;
    req_t       cur;
    logic [W-1:0] old_word;
    logic [W-1:0] new_word;
    logic       alu_we;
    logic       alu_cas;
    logic       alu_miss;
    logic       alu_bad;
    logic       in_write;

    assign req_ready = (state == ST_IDLE);
    assign in_write  = (state == ST_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cur         <= '0;
            done_o      <= 1'b0;
            ret_valid_o <= 1'b0;
            err_o       <= 1'b0;
            rsp_data    <= '0;
        end else begin
            done_o      <= 1'b0;
            ret_valid_o <= 1'b0;
            err_o       <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    cur   <= '{op: req_op, addr: req_addr, opa: req_opa,
                               opb: req_opb, ret: req_ret, sgn: req_signed};
                    state <= ST_READ;
                end
                ST_READ: state <= ST_WRITE;
                ST_WRITE: begin
                    done_o      <= 1'b1;
                    ret_valid_o <= cur.ret & !alu_bad;
                    err_o       <= alu_bad;
                    rsp_data    <= old_word;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    amo_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (cur.addr),
        .rd_data (old_word),
        .we      (in_write & alu_we),
        .wr_addr (cur.addr),
        .wr_data (new_word)
    );

    amo_alu #(.W(W)) u_alu (
        .op       (cur.op),
        .old_val  (old_word),
        .opa      (cur.opa),
        .opb      (cur.opb),
        .sgn      (cur.sgn),
        .new_val  (new_word),
        .wr_en    (alu_we),
        .cas_op   (alu_cas),
        .cas_miss (alu_miss),
        .illegal  (alu_bad)
    );

    amo_cas_stats #(.CW(CW)) u_stats (
        .clk      (clk),
        .rst      (rst),
        .bump     (in_write & alu_cas),
        .miss     (alu_miss),
        .attempts (cas_attempts),
        .fails    (cas_fails)
    );
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done_o,
    input logic          ret_valid_o,
    input logic          err_o,
    input logic [CW-1:0] cas_attempts,
    input logic [CW-1:0] cas_fails
);
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R2

    AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> req_ready); // R2

    AST_RET_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        ret_valid_o |-> done_o); // R9

    AST_ERR_NO_RET: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (done_o && !ret_valid_o)); // R10

    AST_FAILS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cas_fails <= cas_attempts); // R7

    AST_CTR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(cas_attempts) && $stable(cas_fails))); // R7

    AST_ERR_CTR_STILL: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $stable(cas_attempts)); // R10
endmodule

bind amo_unit amo_unit_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .done_o       (done_o),
    .ret_valid_o  (ret_valid_o),
    .err_o        (err_o),
    .cas_attempts (cas_attempts),
    .cas_fails    (cas_fails)
);

// File: tb/tb_amo_unit.sv
module tb_amo_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int DEPTH = 16;
    localparam int CW = 8;
    localparam int AW = $clog2(DEPTH);
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [3:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0] req_opa = '0;
    logic [W-1:0] req_opb = '0;
    logic req_ret = 1'b0;
    logic req_signed = 1'b0;
    logic done_o, ret_valid_o, err_o;
    logic [W-1:0] rsp_data;
    logic [CW-1:0] cas_attempts, cas_fails;

    always #(CLK_PERIOD/2) clk = ~clk;

    amo_unit #(.W(W), .DEPTH(DEPTH), .CW(CW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa),
        .req_opb(req_opb), .req_ret(req_ret), .req_signed(req_signed),
        .done_o(done_o), .ret_valid_o(ret_valid_o), .rsp_data(rsp_data),
        .err_o(err_o), .cas_attempts(cas_attempts), .cas_fails(cas_fails)
    );

    typedef struct {
        bit          rv;
        logic [W-1:0] d;
        bit          e;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [W-1:0] mdl [DEPTH];
    int mdl_att = 0;
    int mdl_fail = 0;
    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // monitor: scoreboard pop on each completion
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R2 unexpected done actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, "ret_valid", {31'b0, ret_valid_o}, {31'b0, e.rv});
                    check(e.tag, "err", {31'b0, err_o}, {31'b0, e.e});
                    if (e.rv) check(e.tag, "old_data", rsp_data, e.d);
                end
            end else if (ret_valid_o || err_o) begin
                n_tests++; n_fail++;
                $display("FAIL R9 strobe without done actual=1 expected=0");
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic send(input int op, input int addr, input logic [W-1:0] a,
                        input logic [W-1:0] b, input bit ret, input bit sgn,
                        input string tag, input bit timing = 0);
        logic [W-1:0] old, nv;
        bit we, bad;
        exp_t e;
        old = mdl[addr];
        nv = old; we = 1; bad = 0;
        case (op)
            0: nv = old & a;
            1: nv = old | a;
            2: nv = old ^ a;
            3: begin
                if (mdl_att < CMAX) mdl_att++;
                if (old == a) nv = b;
                else begin we = 0; if (mdl_fail < CMAX) mdl_fail++; end
            end
            4: nv = a;
            5: nv = old + a;
            6: nv = old - a;
            7: nv = old + 1;
            8: nv = old - 1;
            9: we = sgn ? ($signed(a) > $signed(old)) : (a > old);
            10: we = sgn ? ($signed(a) < $signed(old)) : (a < old);
            default: begin we = 0; bad = 1; end
        endcase
        if (op == 9 || op == 10) nv = a;
        if (we) mdl[addr] = nv;
        e.rv = ret && !bad; e.d = old; e.e = bad; e.tag = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        req_valid = 1; req_op = op[3:0]; req_addr = addr[AW-1:0];
        req_opa = a; req_opb = b; req_ret = ret; req_signed = sgn;
        @(negedge clk);
        req_valid = 0;
        if (timing) begin
            check("R2", "ready busy", {31'b0, req_ready}, 0);
            check("R2", "done early", {31'b0, done_o}, 0);
            @(negedge clk);
            check("R2", "done early2", {31'b0, done_o}, 0);
            @(negedge clk);
            check("R2", "done pulse", {31'b0, done_o}, 1);
            check("R2", "ready back", {31'b0, req_ready}, 1);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input int addr, input string tag);
        send(1, addr, '0, '0, 1, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1", "ready", {31'b0, req_ready}, 1);
        check("R1", "done", {31'b0, done_o}, 0);
        check("R1", "attempts", {24'b0, cas_attempts}, 0);
        check("R1", "fails", {24'b0, cas_fails}, 0);
        rd(3, "R1");
        rd(15, "R1");

        send(4, 1, 32'hA5A5_0F0F, '0, 1, 0, "R2", 1);
        send(4, 1, 32'h1234_5678, '0, 1, 0, "R5");
        rd(1, "R5");

        send(0, 1, 32'h0000_FFFF, '0, 1, 0, "R3");
        send(1, 1, 32'hF000_0000, '0, 1, 0, "R3");
        send(2, 1, 32'hFFFF_FFFF, '0, 1, 0, "R3");
        rd(1, "R3");

        send(5, 2, 32'hFFFF_FFFF, '0, 1, 0, "R4");
        send(7, 2, 32'hDEAD_BEEF, '0, 1, 0, "R4");
        send(8, 2, 32'h0000_0777, '0, 1, 0, "R4");
        send(6, 2, 32'h0000_0005, '0, 1, 0, "R4");
        send(7, 2, '0, '0, 1, 0, "R4");
        rd(2, "R4");

        send(4, 4, 32'h0000_0005, '0, 0, 0, "R8");
        send(9, 4, 32'hFFFF_FFFF, '0, 1, 1, "R8");
        rd(4, "R8");
        send(9, 4, 32'hFFFF_FFFF, '0, 1, 0, "R8");
        send(10, 4, 32'h0000_0003, '0, 1, 1, "R8");
        rd(4, "R8");
        send(10, 4, 32'h0000_0003, '0, 1, 0, "R8");
        send(9, 4, 32'h0000_0003, '0, 1, 1, "R8");
        send(10, 4, 32'h8000_0000, '0, 1, 1, "R8");
        rd(4, "R8");

        send(4, 5, 32'd7, '0, 0, 0, "R6");
        send(3, 5, 32'd7, 32'd9, 1, 0, "R6");
        send(3, 5, 32'd7, 32'd1, 1, 0, "R6");
        rd(5, "R6");
        drain();
        check("R7", "attempts", {24'b0, cas_attempts}, mdl_att);
        check("R7", "fails", {24'b0, cas_fails}, mdl_fail);

        send(4, 6, 32'h55, '0, 0, 0, "R9");
        send(5, 6, 32'h1, '0, 0, 0, "R9");
        rd(6, "R9");

        send(12, 6, '0, '0, 1, 0, "R10");
        send(15, 6, 32'hFFFF_FFFF, '0, 1, 0, "R10");
        send(11, 5, 32'd9, 32'd3, 1, 0, "R10");
        rd(6, "R10");
        rd(5, "R10");
        drain();
        check("R10", "attempts", {24'b0, cas_attempts}, mdl_att);
        check("R10", "fails", {24'b0, cas_fails}, mdl_fail);

        for (int i = 0; i < 260; i++) send(3, 5, '0, 32'd1, (i % 50) == 0, 0, "R7");
        rd(5, "R7");
        drain();
        check("R7", "attempts sat", {24'b0, cas_attempts}, CMAX);
        check("R7", "fails sat", {24'b0, cas_fails}, CMAX);
        send(3, 5, 32'd9, 32'd2, 1, 0, "R7");
        rd(5, "R7");
        drain();
        check("R7", "attempts held", {24'b0, cas_attempts}, CMAX);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule